// File: doc/BRIEF.md
# Serial memory monitor command engine

This block lets a host load, inspect and start programs on a 16-bit processor through a byte stream. It takes command bytes from a receive channel with valid/ready handshake. It acts on a synchronous, byte-addressed memory port with two byte-lane write enables. It answers read requests on a transmit channel that uses the same handshake.

Three command codes exist. Code 0x00 stores a block of bytes. Code 0x01 sends a block of memory bytes back. Code 0x02 asks the attached core to start executing at an address. Each address and each length is two bytes, high byte first. Bit-level serial framing sits outside this block and connects to its byte channels.

Top module: `serial_monitor`

## Requirements
- R1: After reset the engine is idle. rx_ready is 1. tx_valid, mem_re, exec_go and both bits of mem_we are 0, and mem_addr is 0.
- R2: Byte 0x00, then address high, address low, length high, length low, stores the following length data bytes at consecutive addresses, starting at the given address.
- R3: Each stored byte asserts exactly one write enable for one cycle. An even address uses mem_we[0] with the byte on mem_wdata[7:0]. An odd address uses mem_we[1] with the byte on mem_wdata[15:8].
- R4: Byte 0x01, then address high, address low, length high, length low, returns length bytes on tx_data in increasing address order. Each byte comes from the lane chosen as in R3. The memory returns mem_rdata one cycle after a cycle with mem_re high.
- R5: While a returned byte waits with tx_ready low, tx_valid stays 1 and tx_data stays unchanged. No new mem_re is issued until the byte is taken.
- R6: Byte 0x02, then address high, address low, raises exec_go for exactly one cycle with that address on exec_addr. The engine then returns to idle.
- R7: A command byte above 0x02 is dropped. The next byte is again taken as a command.
- R8: A length of zero ends a store or read-back command with no memory access and no transmitted byte.
- R9: The address advances modulo 2^16, so 0xFFFF is followed by 0x0000.
- R10: No receive byte is accepted while a read-back byte is pending (tx_valid high implies rx_ready low). Memory is never read and written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Engine accepts a received byte |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmitter takes the byte |
| mem_addr | output | 16 | Byte address for memory access |
| mem_wdata | output | 16 | Write data, byte copied to both lanes |
| mem_we | output | 2 | Lane write enables, bit 0 even, bit 1 odd |
| mem_re | output | 1 | Read request |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_re |
| exec_go | output | 1 | One-cycle execute strobe |
| exec_addr | output | 16 | Execution start address |

## Verification
The assertions check the following on every cycle:
- At most one write lane is enabled, and it matches address bit 0.
- A pending transmit byte holds steady under backpressure, and no read is issued meanwhile.
- The receive side is closed during a read-back.
- Reads and writes never overlap.
- The execute strobe never lasts more than one cycle.

Only the bench scenarios can show the rest:
- The byte order of the protocol.
- That stored data reads back intact.
- That unknown commands and zero lengths leave memory untouched.
- That the address wraps at 0xFFFF.

// File: rtl/serial_monitor.sv
module serial_monitor (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [1:0]  mem_we,
  output logic        mem_re,
  input  logic [15:0] mem_rdata,
  output logic        exec_go,
  output logic [15:0] exec_addr
);

  typedef enum logic [3:0] {
    S_CMD, S_AH, S_AL, S_LH, S_LL, S_WR, S_RQ, S_RW, S_RC, S_TX
  } st_t;

  st_t         state;
  logic [1:0]  cmd;
  logic [15:0] addr;
  logic [15:0] cnt;

  assign rx_ready = (state == S_CMD) || (state == S_AH) || (state == S_AL) ||
                    (state == S_LH)  || (state == S_LL) || (state == S_WR);

  wire take = rx_valid && rx_ready;
  wire last = (cnt == 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_CMD;
      cmd       <= 2'd0;
      addr      <= 16'd0;
      cnt       <= 16'd0;
      tx_data   <= 8'd0;
      tx_valid  <= 1'b0;
      mem_addr  <= 16'd0;
      mem_wdata <= 16'd0;
      mem_we    <= 2'b00;
      mem_re    <= 1'b0;
      exec_go   <= 1'b0;
      exec_addr <= 16'd0;
    end else begin
      mem_we  <= 2'b00;
      mem_re  <= 1'b0;
      exec_go <= 1'b0;
      case (state)
        S_CMD: if (take) begin
          cmd <= rx_data[1:0];
          if (rx_data <= 8'd2) state <= S_AH;
        end
        S_AH: if (take) begin
          addr[15:8] <= rx_data;
          state      <= S_AL;
        end
        S_AL: if (take) begin
          addr[7:0] <= rx_data;
          if (cmd == 2'd2) begin
            exec_go   <= 1'b1;
            exec_addr <= {addr[15:8], rx_data};
            state     <= S_CMD;
          end else begin
            state <= S_LH;
          end
        end
        S_LH: if (take) begin
          cnt[15:8] <= rx_data;
          state     <= S_LL;
        end
        S_LL: if (take) begin
          cnt[7:0] <= rx_data;
          if ({cnt[15:8], rx_data} == 16'd0) state <= S_CMD;
          else if (cmd == 2'd0)              state <= S_WR;
          else                               state <= S_RQ;
        end
        S_WR: if (take) begin
          mem_addr  <= addr;
          mem_wdata <= {rx_data, rx_data};
          mem_we    <= addr[0] ? 2'b10 : 2'b01;
          addr      <= addr + 16'd1;
          cnt       <= cnt - 16'd1;
          if (last) state <= S_CMD;
        end
        S_RQ: begin
          mem_re   <= 1'b1;
          mem_addr <= addr;
          state    <= S_RW;
        end
        S_RW: state <= S_RC;
        S_RC: begin
          tx_data  <= mem_addr[0] ? mem_rdata[15:8] : mem_rdata[7:0];
          tx_valid <= 1'b1;
          state    <= S_TX;
        end
        S_TX: if (tx_ready) begin
          tx_valid <= 1'b0;
          addr     <= addr + 16'd1;
          cnt      <= cnt - 16'd1;
          state    <= last ? S_CMD : S_RQ;
        end
        default: state <= S_CMD;
      endcase
    end
  end

endmodule

// File: rtl/serial_monitor_chk.sv
module serial_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [15:0] mem_addr,
  input logic [1:0]  mem_we,
  input logic        mem_re,
  input logic        exec_go
);

  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mem_we) <= 1);

  a_r3_even_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[0] |-> !mem_addr[0]);

  a_r3_odd_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[1] |-> mem_addr[0]);

  a_r5_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r5_no_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_re);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !exec_go);

  a_r10_rx_closed: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && (mem_we != 2'b00)));

endmodule

bind serial_monitor serial_monitor_chk chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_re(mem_re), .exec_go(exec_go)
);

// File: tb/serial_monitor_test.sv
module serial_monitor_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'd0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_we;
  logic        mem_re;
  logic [15:0] mem_rdata = 16'd0;
  logic        exec_go;
  logic [15:0] exec_addr;

  int tests = 0;
  int fails = 0;
  int wr_count = 0;
  int exec_count = 0;
  logic [15:0] exec_seen = 16'd0;
  logic [15:0] mem [0:255];

  always #(PERIOD/2) clk = ~clk;

  serial_monitor uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .exec_go(exec_go), .exec_addr(exec_addr)
  );

  always @(posedge clk) begin
    if (mem_we[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
    if (mem_we[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
    if (mem_re)    mem_rdata <= mem[mem_addr[8:1]];
    if (rst_n && mem_we != 2'b00) wr_count <= wr_count + 1;
    if (rst_n && exec_go) begin
      exec_count <= exec_count + 1;
      exec_seen  <= exec_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] c, input logic [15:0] a, input logic [15:0] n);
    send(c); send(a[15:8]); send(a[7:0]); send(n[15:8]); send(n[7:0]);
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  function automatic logic [7:0] lane(input logic [15:0] a);
    return a[0] ? mem[a[8:1]][15:8] : mem[a[8:1]][7:0];
  endfunction

  localparam logic [23:0] VEC [6] = '{
    24'h0000_3C, 24'h0001_A5, 24'h0102_7E,
    24'h00FF_11, 24'h8001_C3, 24'h4444_0F
  };

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int w0;
    int e0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(rx_ready && !tx_valid && !mem_re && mem_we == 2'b00 && !exec_go && mem_addr == 16'd0,
        "R1 reset state", {rx_ready, tx_valid, mem_re, mem_we, exec_go}, 32'h20);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = VEC[i][23:8];
      d = VEC[i][7:0];
      send_hdr(8'h00, a, 16'd1);
      send(d);
      repeat (2) @(negedge clk);
      chk(lane(a) == d, "R3 lane store", lane(a), d);
      send_hdr(8'h01, a, 16'd1);
      recv(b);
      chk(b == d, "R4 single read-back", b, d);
    end

    send_hdr(8'h00, 16'h0010, 16'd4);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    repeat (2) @(negedge clk);
    chk(mem[8] == 16'h2211 && mem[9] == 16'h4433, "R2 block store", {mem[9], mem[8]}, 32'h44332211);
    send_hdr(8'h01, 16'h0010, 16'd4);
    for (int k = 0; k < 4; k++) begin
      recv(b);
      chk(b == 8'(8'h11 * (k + 1)), "R4 block read order", b, 8'(8'h11 * (k + 1)));
    end

    send_hdr(8'h01, 16'h0013, 16'd1);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    repeat (10) @(negedge clk);
    chk(tx_valid && tx_data == b && b == 8'h44, "R5 hold under backpressure", tx_data, 8'h44);
    chk(!rx_ready, "R10 rx closed during read-back", rx_ready, 0);
    recv(b);

    e0 = exec_count;
    send(8'h02); send(8'hBE); send(8'hEF);
    repeat (3) @(negedge clk);
    chk(exec_count == e0 + 1 && exec_seen == 16'hBEEF, "R6 execute strobe", exec_seen, 16'hBEEF);
    chk(!exec_go && rx_ready, "R6 back to idle", {exec_go, rx_ready}, 1);

    w0 = wr_count;
    e0 = exec_count;
    send(8'h07);
    send(8'h02); send(8'h12); send(8'h34);
    repeat (3) @(negedge clk);
    chk(exec_count == e0 + 1 && exec_seen == 16'h1234 && wr_count == w0,
        "R7 unknown command dropped", exec_seen, 16'h1234);

    w0 = wr_count;
    e0 = exec_count;
    send_hdr(8'h00, 16'h0020, 16'd0);
    send(8'h02); send(8'h00); send(8'h55);
    repeat (3) @(negedge clk);
    chk(wr_count == w0 && exec_seen == 16'h0055 && exec_count == e0 + 1,
        "R8 zero-length store", wr_count - w0, 0);
    send_hdr(8'h01, 16'h0020, 16'd0);
    repeat (8) @(negedge clk);
    chk(!tx_valid && rx_ready, "R8 zero-length read-back", tx_valid, 0);

    send_hdr(8'h00, 16'hFFFF, 16'd2);
    send(8'hAA); send(8'hBB);
    repeat (2) @(negedge clk);
    chk(mem[255][15:8] == 8'hAA && mem[0][7:0] == 8'hBB, "R9 address wrap on store",
        {mem[255][15:8], mem[0][7:0]}, 16'hAABB);
    send_hdr(8'h01, 16'hFFFF, 16'd2);
    recv(b);
    chk(b == 8'hAA, "R9 wrap read first", b, 8'hAA);
    recv(b);
    chk(b == 8'hBB, "R9 wrap read second", b, 8'hBB);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule